// File: doc/BRIEF.md
# LCD Frame Header Decoder and Sequencer

This block steps an LCD controller through one frame at a time. When the panel is switched on it checks that the frame buffer addresses fall inside the memory window the controller may reach. Unless the load mode skips it, it then fetches the leading header word of buffer 0, which stands for the palette load. After that, every pulse on `frame_tick` starts one frame. The block fetches the header word of the current buffer, takes the pixel depth from a three-bit code in that word, and works out where the pixel data begins. It then checks that the whole frame fits between the buffer's top and bottom addresses. If the frame fits, it hands a frame descriptor to the pixel engine: base address, depth, line stride, first line, line count and buffer index.

A buffer that is too small sets a sticky sync error, raises the interrupt and turns the panel off. An accepted frame pulses a DMA condition strobe for the buffer it used. In dual-buffer mode, successive frames alternate between buffer 0 and buffer 1.

Header reads and frame descriptors use valid/ready handshakes. A request (`hdr_req_valid`) or a descriptor (`out_valid`) holds its payload stable until the other side takes it. The block accepts a header response only while `hdr_rsp_ready` is high. While a descriptor is waiting, further frame ticks are ignored. Dropping `cfg_enable` abandons any pending handshake at once. Configuration, status and strobes are plain signals.

Top module: `lcdseq_frame_ctrl`

## Requirements
- R1: After reset `lcd_on`, `out_valid`, `hdr_req_valid`, `hdr_rsp_ready`, `frame_done`, `palette_done`, `sync_error` and `irq` are all 0.
- R2: On a rising `cfg_enable`, the top and bottom addresses of buffer 0 are checked against the window MEM_LO..MEM_HI (inclusive). When `cfg_dual` is 1, those of buffer 1 are checked as well. If any checked address lies outside the window, `dma_cond_set` pulses bit 2, `dma_irq` pulses if `cfg_dma_mask[1]` is 1, and `lcd_on` stays 0. When every checked address is valid, `lcd_on` becomes 1.
- R3: A rising `cfg_enable` clears `frame_done` and `palette_done` and starts at buffer index 0. When the load mode is not 2, the block then reads the header at `buf0_top`, and `palette_done` becomes 1 when that read completes.
- R4: The depth code is header bits [14:12]. Code 1 gives 2 bpp, 2 gives 4 bpp, 3 gives 8 bpp, and 4 to 7 give 16 bpp; `out_bpp` carries the bit count. Code 0 drops the frame with no descriptor and no strobe. `out_rgb12` is 1 for 16 bpp when `cfg_tft` is 0.
- R5: The pixel data offset is 0x200 for codes 3 to 7 and 0x20 for codes 0 to 2 when the load mode is not 2, and 0 when the load mode is 2. `out_base` is the buffer top plus this offset.
- R6: A frame needs `offset + width*height*bpp/8` bytes, with width = `cfg_width_m1`+1 and height = `cfg_height_m1`+1. If this exceeds (bottom - top) + 2 of the current buffer, `sync_error` becomes 1, `lcd_on` becomes 0 and no descriptor is produced. A frame that needs exactly (bottom - top) + 2 bytes is accepted.
- R7: An accepted frame pulses `dma_cond_set` bit 0 for buffer 0 or bit 1 for buffer 1, in the cycle `out_valid` rises. It pulses `dma_irq` in that cycle if `cfg_dma_mask[0]` is 1.
- R8: Each frame header is read at the top address of the current buffer. With `cfg_dual` at 1 the buffer index toggles after every accepted frame; with `cfg_dual` at 0 it stays 0.
- R9: When `cfg_sub_en` is 1 and `cfg_sub_from_top` is 1, `out_first_line` equals `cfg_sub_lines` and `out_line_count` equals the height. When `cfg_sub_en` is 1 and `cfg_sub_from_top` is 0, `out_first_line` is 0 and `out_line_count` equals `cfg_sub_lines`. Otherwise `out_first_line` is 0 and `out_line_count` equals the height.
- R10: `out_stride` equals width*bpp/8, rounded down.
- R11: A falling `cfg_enable` turns the panel off and clears `sync_error`. It sets `frame_done` unless the load mode is 1.
- R12: In load mode 1, frame ticks are ignored. In load mode 2, no header is read, either at enable or per frame. The depth code from the last header read is reused; it is 0 after reset.
- R13: `out_valid` and `hdr_req_valid` hold with a stable payload until accepted. Frame ticks that arrive while a frame is in progress have no effect.
- R14: `irq` = (`frame_done` AND `cfg_irq_mask[0]`) OR (`palette_done` AND `cfg_irq_mask[1]`) OR `sync_error`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Panel enable level from the register block |
| cfg_load_mode | input | 2 | 1: no frames; 2: no header reads; other: normal |
| cfg_tft | input | 1 | Active-matrix panel (16 bpp as full colour) |
| cfg_dual | input | 1 | Alternate between two buffers |
| cfg_width_m1 | input | DIM_W | Width minus one |
| cfg_height_m1 | input | DIM_W | Height minus one |
| cfg_sub_en | input | 1 | Subpanel enable |
| cfg_sub_from_top | input | 1 | Subpanel field is the first line (else line count) |
| cfg_sub_lines | input | DIM_W | Subpanel line field |
| cfg_irq_mask | input | 2 | Bit 0 frame-done, bit 1 palette-done interrupt enable |
| cfg_dma_mask | input | 2 | Bit 0 frame-accepted, bit 1 bad-address DMA interrupt enable |
| buf0_top | input | ADDR_W | Buffer 0 top address |
| buf0_bot | input | ADDR_W | Buffer 0 bottom address |
| buf1_top | input | ADDR_W | Buffer 1 top address |
| buf1_bot | input | ADDR_W | Buffer 1 bottom address |
| frame_tick | input | 1 | Start-of-frame pulse |
| hdr_req_valid | output | 1 | Header read request valid |
| hdr_req_ready | input | 1 | Header read request accepted |
| hdr_req_addr | output | ADDR_W | Header read address |
| hdr_rsp_valid | input | 1 | Header data valid |
| hdr_rsp_ready | output | 1 | Block can take header data |
| hdr_rsp_data | input | HDR_W | Header word |
| out_valid | output | 1 | Frame descriptor valid |
| out_ready | input | 1 | Descriptor accepted |
| out_base | output | ADDR_W | Pixel data base address |
| out_bpp | output | 5 | Bits per pixel |
| out_rgb12 | output | 1 | 16 bpp read as 12-bit colour |
| out_first_line | output | DIM_W | First displayed line |
| out_line_count | output | DIM_W+1 | Number of lines |
| out_stride | output | DIM_W+2 | Line stride in bytes |
| out_frame | output | 1 | Buffer index used |
| lcd_on | output | 1 | Panel running |
| frame_done | output | 1 | Frame-done status |
| palette_done | output | 1 | Palette-loaded status |
| sync_error | output | 1 | Sticky buffer-underrun error |
| irq | output | 1 | Interrupt level |
| dma_cond_set | output | 3 | One-cycle DMA condition strobes |
| dma_irq | output | 1 | One-cycle DMA interrupt pulse |

## Verification
The bench aims at the fit boundary, where the needed byte count sits at size+2, size+3 and size+1. An off-by-one comparator would either shut the panel down on a legal frame or let a frame overrun its buffer, and the largest 1024x1024 16-bpp frame also exposes a truncated byte counter. Header code 0 and the code-3 offset step are driven directly. A wrong table would emit a descriptor for an aborted frame or shift the pixel base by the wrong amount. Buffer alternation, load modes 1 and 2, and a descriptor held back by `out_ready` are each exercised. A design that toggled on aborted frames, read headers in mode 2, or let its payload drift under back-pressure would give a wrong address or field in the next descriptor.

// File: rtl/lcdseq_pkg.sv
package lcdseq_pkg;
  typedef enum logic [2:0] {
    ST_OFF, ST_PAL_REQ, ST_PAL_WAIT, ST_WAIT_TICK,
    ST_HDR_REQ, ST_HDR_WAIT, ST_CALC, ST_EMIT
  } seq_state_e;

  localparam logic [1:0] LM_NO_FRAME = 2'd1;
  localparam logic [1:0] LM_NO_PAL   = 2'd2;
  localparam logic [1:0] IDX_IDLE    = 2'b11;

  // log2 of the pixel depth for a header code; 0 marks an abort code
  function automatic logic [2:0] depth_log(input logic [2:0] code);
    case (code)
      3'd0:    depth_log = 3'd0;
      3'd1:    depth_log = 3'd1;
      3'd2:    depth_log = 3'd2;
      3'd3:    depth_log = 3'd3;
      default: depth_log = 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/lcdseq_hdr_decode.sv
module lcdseq_hdr_decode
  import lcdseq_pkg::*;
#(
  parameter int OFS_W = 10
) (
  input  logic [2:0]       code,
  input  logic [1:0]       load_mode,
  output logic             abort,
  output logic [2:0]       bpp_log,
  output logic [4:0]       bpp,
  output logic [OFS_W-1:0] offset
);
  localparam logic [OFS_W-1:0] OFS_BIG   = OFS_W'(10'h200);
  localparam logic [OFS_W-1:0] OFS_SMALL = OFS_W'(10'h020);

  always_comb begin
    abort   = (code == 3'd0);
    bpp_log = depth_log(code);
    bpp     = 5'd1 << bpp_log;
    if (load_mode == LM_NO_PAL)
      offset = '0;
    else if (code >= 3'd3)
      offset = OFS_BIG;
    else
      offset = OFS_SMALL;
  end
endmodule

// File: rtl/lcdseq_fit_check.sv
module lcdseq_fit_check #(
  parameter int ADDR_W = 32,
  parameter int DIM_W  = 10,
  parameter int OFS_W  = 10
) (
  input  logic [DIM_W-1:0]  width_m1,
  input  logic [DIM_W-1:0]  height_m1,
  input  logic [2:0]        bpp_log,
  input  logic [OFS_W-1:0]  offset,
  input  logic [ADDR_W-1:0] top,
  input  logic [ADDR_W-1:0] bot,
  output logic              fits,
  output logic [DIM_W:0]    height,
  output logic [DIM_W+1:0]  stride,
  output logic [ADDR_W-1:0] base
);
  localparam int PIX_W   = 2 * (DIM_W + 1);
  localparam int SH_W    = PIX_W + 4;
  localparam int BYTES_W = SH_W - 3;
  localparam int WIDEST  = (ADDR_W > SH_W) ? ADDR_W : SH_W;
  localparam int CMP_W   = WIDEST + 3;

  logic [DIM_W:0]         width;
  logic [PIX_W-1:0]       pixels;
  logic [SH_W-1:0]        pix_bits;
  logic [BYTES_W-1:0]     bytes;
  logic [DIM_W+4:0]       line_bits;
  logic signed [CMP_W-1:0] need, room;

  always_comb begin
    width     = {1'b0, width_m1} + 1'b1;
    height    = {1'b0, height_m1} + 1'b1;
    pixels    = PIX_W'(width) * PIX_W'(height);
    pix_bits  = {4'b0, pixels} << bpp_log;
    bytes     = pix_bits[SH_W-1:3];
    line_bits = {4'b0, width} << bpp_log;
    stride    = line_bits[DIM_W+4:3];
    need      = $signed(CMP_W'(offset) + CMP_W'(bytes));
    room      = $signed(CMP_W'(bot)) - $signed(CMP_W'(top)) + $signed(CMP_W'(2));
    fits      = (need <= room);
    base      = top + ADDR_W'(offset);
  end
endmodule

// File: rtl/lcdseq_addr_window.sv
module lcdseq_addr_window #(
  parameter int                ADDR_W = 32,
  parameter int                NUM    = 4,
  parameter logic [ADDR_W-1:0] LO     = '0,
  parameter logic [ADDR_W-1:0] HI     = '1
) (
  input  logic [NUM*ADDR_W-1:0] addrs,
  input  logic [NUM-1:0]        check,
  output logic                  all_ok
);
  logic [NUM-1:0] bad;

  for (genvar g = 0; g < NUM; g++) begin : g_win
    logic [ADDR_W-1:0] a;
    assign a      = addrs[g*ADDR_W +: ADDR_W];
    assign bad[g] = check[g] && ((a < LO) || (a > HI));
  end

  assign all_ok = ~|bad;
endmodule

// File: rtl/lcdseq_frame_ctrl.sv
module lcdseq_frame_ctrl
  import lcdseq_pkg::*;
#(
  parameter int                ADDR_W = 32,
  parameter int                DIM_W  = 10,
  parameter int                HDR_W  = 16,
  parameter logic [ADDR_W-1:0] MEM_LO = ADDR_W'(32'h1000_0000),
  parameter logic [ADDR_W-1:0] MEM_HI = ADDR_W'(32'h1FFF_FFFF)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_enable,
  input  logic [1:0]        cfg_load_mode,
  input  logic              cfg_tft,
  input  logic              cfg_dual,
  input  logic [DIM_W-1:0]  cfg_width_m1,
  input  logic [DIM_W-1:0]  cfg_height_m1,
  input  logic              cfg_sub_en,
  input  logic              cfg_sub_from_top,
  input  logic [DIM_W-1:0]  cfg_sub_lines,
  input  logic [1:0]        cfg_irq_mask,
  input  logic [1:0]        cfg_dma_mask,
  input  logic [ADDR_W-1:0] buf0_top,
  input  logic [ADDR_W-1:0] buf0_bot,
  input  logic [ADDR_W-1:0] buf1_top,
  input  logic [ADDR_W-1:0] buf1_bot,
  input  logic              frame_tick,
  output logic              hdr_req_valid,
  input  logic              hdr_req_ready,
  output logic [ADDR_W-1:0] hdr_req_addr,
  input  logic              hdr_rsp_valid,
  output logic              hdr_rsp_ready,
  input  logic [HDR_W-1:0]  hdr_rsp_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_base,
  output logic [4:0]        out_bpp,
  output logic              out_rgb12,
  output logic [DIM_W-1:0]  out_first_line,
  output logic [DIM_W:0]    out_line_count,
  output logic [DIM_W+1:0]  out_stride,
  output logic              out_frame,
  output logic              lcd_on,
  output logic              frame_done,
  output logic              palette_done,
  output logic              sync_error,
  output logic              irq,
  output logic [2:0]        dma_cond_set,
  output logic              dma_irq
);
  localparam int OFS_W    = 10;
  localparam int CODE_LSB = 12;

  seq_state_e        state;
  logic              en_q;
  logic [1:0]        cur_idx;
  logic [2:0]        code_q;
  logic [ADDR_W-1:0] req_addr_q;

  logic              en_rise, en_fall;
  logic              bufs_ok;
  logic [ADDR_W-1:0] cur_top, cur_bot;
  logic              dec_abort;
  logic [2:0]        dec_log;
  logic [4:0]        dec_bpp;
  logic [OFS_W-1:0]  dec_ofs;
  logic              fit_ok;
  logic [DIM_W:0]    fit_height;
  logic [DIM_W+1:0]  fit_stride;
  logic [ADDR_W-1:0] fit_base;
  logic              unused_hdr_bits;

  assign en_rise = cfg_enable && !en_q;
  assign en_fall = !cfg_enable && en_q;
  assign cur_top = cur_idx[0] ? buf1_top : buf0_top;
  assign cur_bot = cur_idx[0] ? buf1_bot : buf0_bot;
  assign unused_hdr_bits = ^{hdr_rsp_data[HDR_W-1:CODE_LSB+3], hdr_rsp_data[CODE_LSB-1:0]};

  lcdseq_addr_window #(
    .ADDR_W (ADDR_W),
    .NUM    (4),
    .LO     (MEM_LO),
    .HI     (MEM_HI)
  ) u_window (
    .addrs  ({buf1_bot, buf1_top, buf0_bot, buf0_top}),
    .check  ({cfg_dual, cfg_dual, 2'b11}),
    .all_ok (bufs_ok)
  );

  lcdseq_hdr_decode #(.OFS_W(OFS_W)) u_decode (
    .code      (code_q),
    .load_mode (cfg_load_mode),
    .abort     (dec_abort),
    .bpp_log   (dec_log),
    .bpp       (dec_bpp),
    .offset    (dec_ofs)
  );

  lcdseq_fit_check #(
    .ADDR_W (ADDR_W),
    .DIM_W  (DIM_W),
    .OFS_W  (OFS_W)
  ) u_fit (
    .width_m1  (cfg_width_m1),
    .height_m1 (cfg_height_m1),
    .bpp_log   (dec_log),
    .offset    (dec_ofs),
    .top       (cur_top),
    .bot       (cur_bot),
    .fits      (fit_ok),
    .height    (fit_height),
    .stride    (fit_stride),
    .base      (fit_base)
  );

  assign hdr_req_valid = (state == ST_PAL_REQ) || (state == ST_HDR_REQ);
  assign hdr_req_addr  = req_addr_q;
  assign hdr_rsp_ready = (state == ST_PAL_WAIT) || (state == ST_HDR_WAIT);
  assign irq = (frame_done && cfg_irq_mask[0]) || (palette_done && cfg_irq_mask[1]) || sync_error;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state          <= ST_OFF;
      en_q           <= 1'b0;
      cur_idx        <= IDX_IDLE;
      code_q         <= 3'd0;
      req_addr_q     <= '0;
      lcd_on         <= 1'b0;
      frame_done     <= 1'b0;
      palette_done   <= 1'b0;
      sync_error     <= 1'b0;
      dma_cond_set   <= 3'b000;
      dma_irq        <= 1'b0;
      out_valid      <= 1'b0;
      out_base       <= '0;
      out_bpp        <= '0;
      out_rgb12      <= 1'b0;
      out_first_line <= '0;
      out_line_count <= '0;
      out_stride     <= '0;
      out_frame      <= 1'b0;
    end else begin
      en_q         <= cfg_enable;
      dma_cond_set <= 3'b000;
      dma_irq      <= 1'b0;
      if (en_fall) begin
        state      <= ST_OFF;
        lcd_on     <= 1'b0;
        cur_idx    <= IDX_IDLE;
        sync_error <= 1'b0;
        out_valid  <= 1'b0;
        if (cfg_load_mode != LM_NO_FRAME) frame_done <= 1'b1;
      end else if (en_rise) begin
        frame_done   <= 1'b0;
        palette_done <= 1'b0;
        if (bufs_ok) begin
          lcd_on     <= 1'b1;
          cur_idx    <= 2'd0;
          req_addr_q <= buf0_top;
          state      <= (cfg_load_mode == LM_NO_PAL) ? ST_WAIT_TICK : ST_PAL_REQ;
        end else begin
          dma_cond_set <= 3'b100;
          dma_irq      <= cfg_dma_mask[1];
        end
      end else begin
        case (state)
          ST_PAL_REQ:  if (hdr_req_ready) state <= ST_PAL_WAIT;
          ST_PAL_WAIT: if (hdr_rsp_valid) begin
            code_q       <= hdr_rsp_data[CODE_LSB +: 3];
            palette_done <= 1'b1;
            state        <= ST_WAIT_TICK;
          end
          ST_WAIT_TICK: if (frame_tick && cfg_load_mode != LM_NO_FRAME) begin
            req_addr_q <= cur_top;
            state      <= (cfg_load_mode == LM_NO_PAL) ? ST_CALC : ST_HDR_REQ;
          end
          ST_HDR_REQ:  if (hdr_req_ready) state <= ST_HDR_WAIT;
          ST_HDR_WAIT: if (hdr_rsp_valid) begin
            code_q <= hdr_rsp_data[CODE_LSB +: 3];
            state  <= ST_CALC;
          end
          ST_CALC: begin
            if (dec_abort) begin
              state <= ST_WAIT_TICK;
            end else if (!fit_ok) begin
              sync_error <= 1'b1;
              lcd_on     <= 1'b0;
              cur_idx    <= IDX_IDLE;
              state      <= ST_OFF;
            end else begin
              out_valid      <= 1'b1;
              out_base       <= fit_base;
              out_bpp        <= dec_bpp;
              out_rgb12      <= (dec_log == 3'd4) && !cfg_tft;
              out_stride     <= fit_stride;
              out_frame      <= cur_idx[0];
              out_first_line <= (cfg_sub_en && cfg_sub_from_top) ? cfg_sub_lines : '0;
              out_line_count <= (cfg_sub_en && !cfg_sub_from_top) ? {1'b0, cfg_sub_lines}
                                                                   : fit_height;
              dma_cond_set   <= cur_idx[0] ? 3'b010 : 3'b001;
              dma_irq        <= cfg_dma_mask[0];
              if (cfg_dual) cur_idx <= {1'b0, ~cur_idx[0]};
              state          <= ST_EMIT;
            end
          end
          ST_EMIT: if (out_ready) begin
            out_valid <= 1'b0;
            state     <= ST_WAIT_TICK;
          end
          default: state <= ST_OFF;
        endcase
      end
    end
  end
endmodule

// File: rtl/lcdseq_frame_ctrl_chk.sv
module lcdseq_frame_ctrl_chk #(
  parameter int ADDR_W = 32,
  parameter int DIM_W  = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_enable,
  input logic              out_valid,
  input logic              out_ready,
  input logic [ADDR_W-1:0] out_base,
  input logic [4:0]        out_bpp,
  input logic [DIM_W:0]    out_line_count,
  input logic              hdr_req_valid,
  input logic              hdr_req_ready,
  input logic [ADDR_W-1:0] hdr_req_addr,
  input logic              lcd_on,
  input logic              sync_error,
  input logic              irq,
  input logic [2:0]        dma_cond_set
);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !lcd_on |-> (!hdr_req_valid && !out_valid));

  a_r4_bpp_legal: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($countones(out_bpp) == 1 && !out_bpp[0]));

  a_r6_sync_offline: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_error) |-> !lcd_on);

  a_r7_cond_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dma_cond_set));

  a_r7_cond_with_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (|dma_cond_set[1:0]) |-> out_valid);

  a_r13_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && cfg_enable) |=>
      (out_valid && $stable(out_base) && $stable(out_bpp) && $stable(out_line_count)));

  a_r13_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_req_valid && !hdr_req_ready && cfg_enable) |=> (hdr_req_valid && $stable(hdr_req_addr)));

  a_r14_sync_irq: assert property (@(posedge clk) disable iff (!rst_n)
    sync_error |-> irq);
endmodule

bind lcdseq_frame_ctrl lcdseq_frame_ctrl_chk #(.ADDR_W(ADDR_W), .DIM_W(DIM_W)) chk_i (.*);

// File: tb/lcdseq_frame_ctrl_tb.sv
`timescale 1ns/1ps
module lcdseq_frame_ctrl_tb_top;
  localparam int AW = 32;
  localparam int DW = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_enable = 0, cfg_tft = 0, cfg_dual = 0, cfg_sub_en = 0, cfg_sub_from_top = 0;
  logic [1:0] cfg_load_mode = 0, cfg_irq_mask = 0, cfg_dma_mask = 0;
  logic [DW-1:0] cfg_width_m1 = 0, cfg_height_m1 = 0, cfg_sub_lines = 0;
  logic [AW-1:0] buf0_top = 32'h1000_0000, buf0_bot = 32'h1001_0000;
  logic [AW-1:0] buf1_top = 32'h1800_0000, buf1_bot = 32'h1801_0000;
  logic frame_tick = 0, hdr_req_ready = 0, hdr_rsp_valid = 0, out_ready = 0;
  logic [15:0] hdr_rsp_data = 0;
  logic hdr_req_valid, hdr_rsp_ready, out_valid, out_rgb12, out_frame;
  logic [AW-1:0] hdr_req_addr, out_base;
  logic [4:0] out_bpp;
  logic [DW-1:0] out_first_line;
  logic [DW:0] out_line_count;
  logic [DW+1:0] out_stride;
  logic lcd_on, frame_done, palette_done, sync_error, irq, dma_irq;
  logic [2:0] dma_cond_set;

  int checks = 0, errors = 0, cyc = 0;
  int cnt_c0 = 0, cnt_c1 = 0, cnt_c2 = 0, cnt_dirq = 0;
  int cur_exp = 0, last_code = 0;

  lcdseq_frame_ctrl dut_i (.*);

  always #10 clk = ~clk;

  always @(negedge clk) if (rst_n) begin
    if (dma_cond_set[0]) cnt_c0++;
    if (dma_cond_set[1]) cnt_c1++;
    if (dma_cond_set[2]) cnt_c2++;
    if (dma_irq) cnt_dirq++;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errors++;
      $display("FAIL R13 watchdog expired actual %0d expected <150000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic int e_log(int code);
    return (code >= 4) ? 4 : code;
  endfunction
  function automatic int e_off(int code, int lm);
    if (lm == 2) return 0;
    return (code >= 3) ? 512 : 32;
  endfunction

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic serve_hdr(input int code, input longint exp_addr, input string tag);
    int n = 0;
    while (!hdr_req_valid && n < 20) begin step(); n++; end
    chk(hdr_req_valid, {tag, " header request"}, hdr_req_valid, 1);
    if (!hdr_req_valid) return;
    chk(hdr_req_addr == exp_addr[AW-1:0], {tag, " header address"}, hdr_req_addr, exp_addr);
    repeat ($urandom % 3) step();
    hdr_req_ready = 1; step(); hdr_req_ready = 0;
    repeat ($urandom % 3) step();
    hdr_rsp_data = {1'b0, 3'(code), 12'($urandom)};
    hdr_rsp_valid = 1;
    n = 0;
    while (!hdr_rsp_ready && n < 20) begin step(); n++; end
    step();
    hdr_rsp_valid = 0;
    last_code = code;
  endtask

  task automatic restart(input int pal_code);
    cfg_enable = 0; step(); step();
    cfg_enable = 1; step(); step();
    cur_exp = 0;
    if (cfg_load_mode != 2) serve_hdr(pal_code, buf0_top, "R3 palette");
  endtask

  task automatic do_frame(input int code, input int wm1, input int hm1, input int slack,
                          input bit sen, input bit stop, input int sval,
                          input bit dual, input bit dm0, input int dly);
    int lm = int'(cfg_load_mode);
    int eff, lg, off, n;
    longint w, h, need, top, bts, exp_first, exp_lines;
    bit fits;
    int s0, s1, s2, sd;
    cfg_width_m1 = DW'(wm1); cfg_height_m1 = DW'(hm1);
    cfg_sub_en = sen; cfg_sub_from_top = stop; cfg_sub_lines = DW'(sval);
    cfg_dual = dual; cfg_dma_mask[0] = dm0; cfg_tft = 1'($urandom);
    eff = (lm == 2) ? last_code : code;
    w = wm1 + 1; h = hm1 + 1; lg = e_log(eff); off = e_off(eff, lm);
    need = off + (((w * h) << lg) >> 3);
    top = (cur_exp == 1) ? longint'(buf1_top) : longint'(buf0_top);
    bts = top + need - 2 + slack;
    if (cur_exp == 1) buf1_bot = AW'(bts); else buf0_bot = AW'(bts);
    fits = (slack >= 0);
    s0 = cnt_c0; s1 = cnt_c1; s2 = cnt_c2; sd = cnt_dirq;
    frame_tick = 1; step(); frame_tick = 0;
    if (lm != 2) serve_hdr(code, top, "R8");
    if (eff == 0) begin
      n = 0;
      repeat (6) begin step(); if (out_valid) n++; end
      chk(n == 0, "R4 code 0 dropped", n, 0);
      chk(cnt_c0 + cnt_c1 == s0 + s1, "R4 code 0 no strobe", cnt_c0 + cnt_c1, s0 + s1);
      chk(lcd_on == 1, "R4 code 0 panel stays on", lcd_on, 1);
      return;
    end
    n = 0;
    while (!out_valid && lcd_on && n < 12) begin step(); n++; end
    if (!fits) begin
      chk(!out_valid && !lcd_on, "R6 undersized buffer stops panel", lcd_on, 0);
      chk(sync_error == 1, "R6 sync error set", sync_error, 1);
      chk(irq == 1, "R14 irq on sync error", irq, 1);
      chk(cnt_c0 + cnt_c1 == s0 + s1, "R6 no strobe", cnt_c0 + cnt_c1, s0 + s1);
      cur_exp = 0;
      return;
    end
    chk(out_valid == 1, "R6 fitting frame accepted", out_valid, 1);
    if (!out_valid) return;
    exp_first = (sen && stop) ? sval : 0;
    exp_lines = (sen && !stop) ? sval : h;
    chk(out_bpp == 5'(1 << lg), "R4 bpp", out_bpp, 1 << lg);
    chk(out_rgb12 == ((eff >= 4) && !cfg_tft), "R4 rgb12", out_rgb12, (eff >= 4) && !cfg_tft);
    chk(out_base == AW'(top + off), "R5 base", out_base, top + off);
    chk(out_stride == 12'((w << lg) >> 3), "R10 stride", out_stride, (w << lg) >> 3);
    chk(out_first_line == DW'(exp_first), "R9 first line", out_first_line, exp_first);
    chk(out_line_count == 11'(exp_lines), "R9 line count", out_line_count, exp_lines);
    chk(out_frame == 1'(cur_exp), "R8 buffer index", out_frame, cur_exp);
    chk((cur_exp == 0) ? (cnt_c0 == s0 + 1 && cnt_c1 == s1) : (cnt_c1 == s1 + 1 && cnt_c0 == s0),
        "R7 cond bit", cnt_c0 + 2 * cnt_c1, s0 + 2 * s1 + cur_exp + 1);
    chk(cnt_dirq == sd + int'(dm0), "R7 dma irq", cnt_dirq - sd, dm0);
    chk(cnt_c2 == s2, "R7 no bad-address strobe", cnt_c2, s2);
    repeat (dly) begin
      frame_tick = 1; step(); frame_tick = 0;
      chk(out_valid && out_base == AW'(top + off), "R13 hold under back-pressure", out_base, top + off);
      chk(!hdr_req_valid, "R13 tick ignored while busy", hdr_req_valid, 0);
    end
    out_ready = 1; step(); out_ready = 0;
    chk(!out_valid, "R13 descriptor released", out_valid, 0);
    if (dual) cur_exp ^= 1;
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) step();
    chk(!lcd_on && !out_valid && !hdr_req_valid && !hdr_rsp_ready, "R1 reset outputs", lcd_on, 0);
    chk(!frame_done && !palette_done && !sync_error && !irq, "R1 reset status", irq, 0);
    rst_n = 1; step();

    // R2 bad buffer 1 address in dual mode
    buf1_top = 32'h0000_1000; cfg_dual = 1; cfg_dma_mask = 2'b10; cfg_irq_mask = 2'b11;
    cfg_enable = 1; step(); step();
    chk(cnt_c2 == 1 && cnt_dirq == 1, "R2 bad address strobes", cnt_c2 + cnt_dirq, 2);
    chk(!lcd_on && !hdr_req_valid, "R2 panel stays off", lcd_on, 0);
    cfg_enable = 0; step(); step();
    chk(frame_done == 1 && irq == 1, "R11 frame done on disable", frame_done, 1);
    // R2 single mode ignores buffer 1
    cfg_dual = 0; cfg_enable = 1; step();
    chk(lcd_on == 1 && cnt_c2 == 1, "R2 single mode skips buffer 1", lcd_on, 1);
    chk(!frame_done && !palette_done, "R3 status cleared on enable", frame_done, 0);
    buf1_top = 32'h1800_0000;
    cfg_irq_mask = 2'b10;
    serve_hdr(3, buf0_top, "R3 palette");
    step();
    chk(palette_done == 1 && irq == 1, "R3 palette done and R14 irq", palette_done, 1);
    cfg_enable = 0; step(); step();

    restart(1 + $urandom % 7);
    for (int i = 0; i < 60; i++) begin
      int sl = (($urandom % 3) == 0) ? int'($urandom % 7) - 3 : 100;
      do_frame(int'($urandom % 8), int'($urandom % 64), int'($urandom % 48), sl,
               1'($urandom), 1'($urandom), int'($urandom % 1024), 1'($urandom),
               1'($urandom), int'($urandom % 3));
      if (!lcd_on) restart(1 + $urandom % 7);
    end

    // largest frame at the exact boundary, then one byte short
    cfg_dual = 0; restart(4);
    do_frame(4, 1023, 1023, 0, 0, 0, 0, 0, 1, 1);
    do_frame(4, 1023, 1023, -1, 0, 0, 0, 0, 1, 0);
    chk(sync_error == 1, "R6 one byte short", sync_error, 1);
    cfg_load_mode = 1; cfg_enable = 0; step(); step();
    chk(!sync_error && !frame_done, "R11 disable in mode 1", frame_done, 0);

    // load mode 1 ignores ticks
    cfg_enable = 1; step(); step(); cur_exp = 0;
    serve_hdr(2, buf0_top, "R3 palette");
    frame_tick = 1; step(); frame_tick = 0;
    begin
      int n = 0;
      repeat (6) begin step(); if (hdr_req_valid || out_valid) n++; end
      chk(n == 0, "R12 mode 1 ignores tick", n, 0);
    end
    cfg_load_mode = 0; cfg_enable = 0; step(); step();
    chk(frame_done == 1, "R11 frame done in mode 0", frame_done, 1);

    // load mode 2: no header read, last code reused, no offset
    cfg_load_mode = 2; cfg_enable = 1; step();
    begin
      int n = 0;
      repeat (5) begin step(); if (hdr_req_valid) n++; end
      chk(n == 0 && !palette_done, "R12 mode 2 skips palette", n, 0);
    end
    cur_exp = 0;
    do_frame(0, 19, 9, 50, 0, 0, 0, 1, 0, 0);
    do_frame(0, 7, 3, 50, 1, 0, 2, 1, 1, 2);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule